// File: doc/BRIEF.md
# Two-Request Priority Grant Controller

This controller arbitrates between two request lines and always drives exactly one of two registered grant outputs. The high-priority request wins whenever it is sampled. Once it has been seen, its grant stays asserted for a fixed window of following cycles. If the request is sampled again during that window, the window starts over.

When the high-priority request has been quiet for the whole window, the grant returns to the low-priority line. The controller never withholds both grants. With no requests at all, the grant rests on the low-priority line. The low-priority request therefore needs no logic of its own: it is served on every cycle in which no high-priority window is open.

The hold window length is a parameter with a default of two cycles. Reset is asynchronous and active-low. The reset input is expected to be released synchronously to the clock.

Top module: `prio_grant_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, gnt_lo is 1 and gnt_hi is 0, whatever the request inputs are doing.
- R2: Whenever req_hi is sampled high at a clock edge, gnt_hi is 1 in each of the following HOLD_CYCLES cycles (default 2).
- R3: gnt_hi and gnt_lo are never 1 in the same cycle.
- R4: In every cycle exactly one grant is 1, so gnt_lo is 1 whenever gnt_hi is 0 (parking on the low line).
- R5: If req_hi is sampled low at HOLD_CYCLES consecutive edges, gnt_hi is 0 in the cycle after the last of those edges.
- R6: A req_hi sample that falls inside an open window restarts it, so gnt_hi stays 1 until HOLD_CYCLES cycles after the last high sample.
- R7: req_lo has no effect on either grant. When req_lo is the only request and no window is open, gnt_lo is 1 in the next cycle.
- R8: A single-cycle pulse on req_hi with req_lo held low gives exactly HOLD_CYCLES cycles of gnt_hi, after which gnt_lo returns.
- R9: When both requests are sampled high together, the grant in the next cycle goes to the high line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_hi | input | 1 | High-priority request |
| req_lo | input | 1 | Low-priority request |
| gnt_hi | output | 1 | Registered grant to the high-priority requester |
| gnt_lo | output | 1 | Registered grant to the low-priority requester, the parking grant |

## Verification
The only internal state is the hold counter, and the grant register is loaded from that counter's next value. Any error in the counter therefore shows up on gnt_hi in the very next cycle. A counter that reloads short makes the grant drop one cycle early after a single pulse. A counter that fails to reach zero keeps the grant high past the release point. Errors in the one-hot grant encoding show at once as both grants high or both low. For these reasons the bench compares both grants against an independent model on every cycle, under directed pulses, back-to-back requests and random traffic.

// File: rtl/prio_grant_pkg.sv
package prio_grant_pkg;
  // One-hot grant selection; bit 1 = high line, bit 0 = low line.
  typedef enum logic [1:0] {
    GRANT_LO = 2'b01,
    GRANT_HI = 2'b10
  } grant_sel_e;

  function automatic int unsigned cnt_width(input int unsigned hold);
    return (hold < 1) ? 1 : $clog2(hold + 1);
  endfunction
endpackage

// File: rtl/prio_hold_timer.sv
module prio_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 2,
  localparam int unsigned CNT_W = prio_grant_pkg::cnt_width(HOLD_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic active_next
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Next state: reload on trigger, otherwise count down to zero.
  always_comb begin
    cnt_en = trigger || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (trigger) begin
      cnt_d = RELOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign active_next = (cnt_d != '0);

  // R6: a trigger always leaves a full window behind it
  p_reload_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> (cnt_q == RELOAD));

  // R2: the counter never runs past its reload value
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RELOAD);

  // R5: without a trigger the counter only moves downward
  p_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !trigger |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/prio_grant_reg.sv
module prio_grant_reg
  import prio_grant_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  grant_sel_e sel_next,
  output logic       gnt_hi,
  output logic       gnt_lo
);
  grant_sel_e sel_q;
  logic       sel_en;

  // Only load the register when the selection changes.
  always_comb begin
    sel_en = (sel_next != sel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= GRANT_LO;
    end else if (sel_en) begin
      sel_q <= sel_next;
    end
  end

  assign gnt_hi = sel_q[1];
  assign gnt_lo = sel_q[0];

  // R4: exactly one grant bit is set in every cycle
  p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gnt_hi, gnt_lo}) == 1);

  // R3: the two grants never overlap
  p_mutex_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_hi, gnt_lo}));
endmodule

// File: rtl/prio_grant_ctrl.sv
module prio_grant_ctrl
  import prio_grant_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_hi,
  input  logic req_lo,
  output logic gnt_hi,
  output logic gnt_lo
);
  localparam int unsigned RUN_W = cnt_width(HOLD_CYCLES);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(HOLD_CYCLES);

  logic       hold_next;
  grant_sel_e sel_next;

  prio_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .trigger     (req_hi),
    .active_next (hold_next)
  );

  // The high line wins whenever its window is open; otherwise park low.
  // req_lo needs no term: the low line owns every cycle left over.
  always_comb begin
    sel_next = hold_next ? GRANT_HI : GRANT_LO;
  end

  prio_grant_reg u_grant (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_next (sel_next),
    .gnt_hi   (gnt_hi),
    .gnt_lo   (gnt_lo)
  );

  // Checker state: consecutive low samples of req_hi, saturating.
  logic [RUN_W-1:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q <= RUN_MAX;
    end else if (req_hi) begin
      low_run_q <= '0;
    end else if (low_run_q != RUN_MAX) begin
      low_run_q <= low_run_q + 1'b1;
    end
  end

  // R2, R6: an open window (fewer lows than the hold length) means gnt_hi
  p_window_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (low_run_q < RUN_MAX) |-> gnt_hi);

  // R5: a full run of low samples releases the high grant
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (low_run_q == RUN_MAX) |-> !gnt_hi);

  // R9: a sampled high request takes the next grant regardless of req_lo
  p_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hi && req_lo) |=> (gnt_hi && !gnt_lo));

  // R7: a lone low request with the window about to close is served next
  p_lone_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_lo && !req_hi && (low_run_q >= RUN_MAX - 1'b1)) |=> gnt_lo);
endmodule

// File: tb/tb_prio_grant_ctrl.sv
`timescale 1ns/1ps
module tb_prio_grant_ctrl;
  localparam int HOLD = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic req_hi;
  logic req_lo;
  logic gnt_hi;
  logic gnt_lo;

  int tests = 0;
  int fails = 0;
  int m_cnt = 0;
  bit done = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk; // 50 MHz

  prio_grant_ctrl #(.HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .req_hi(req_hi), .req_lo(req_lo),
    .gnt_hi(gnt_hi), .gnt_lo(gnt_lo)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: apply one cycle of requests and push the model's expectation.
  task automatic drive(input logic hi, input logic lo, input string tag);
    @(negedge clk);
    req_hi = hi;
    req_lo = lo;
    if (hi) m_cnt = HOLD;
    else if (m_cnt > 0) m_cnt--;
    exp_q.push_back(m_cnt != 0);
    tag_q.push_back(tag);
  endtask

  // Monitor: after each edge, compare the grants with the queued item.
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, gnt_hi, e);
      check("R4", gnt_lo, !e);
      check("R3", gnt_hi & gnt_lo, 1'b0);
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_hi = 1'b1; // R1: requests during reset are ignored
    req_lo = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", gnt_lo, 1'b1);
    check("R1", gnt_hi, 1'b0);
    req_hi = 1'b0;
    req_lo = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", gnt_lo, 1'b1);
    check("R1", gnt_hi, 1'b0);

    // R8: one-cycle pulse with req_lo low
    drive(1, 0, "R8");
    for (int i = 0; i < 4; i++) drive(0, 0, "R8");
    // R2 / R5: pulse then two lows release
    drive(1, 0, "R2");
    drive(0, 0, "R2");
    drive(0, 0, "R5");
    drive(0, 0, "R5");
    // R6: retrigger during the window extends it
    drive(1, 0, "R6");
    drive(0, 0, "R6");
    drive(1, 0, "R6");
    drive(0, 0, "R6");
    drive(0, 1, "R6");
    drive(0, 0, "R6");
    // R9: both requests together
    drive(1, 1, "R9");
    drive(1, 1, "R9");
    drive(0, 1, "R9");
    // R7: req_lo toggling has no effect; lone req_lo served
    for (int i = 0; i < 4; i++) drive(0, i % 2, "R7");
    drive(0, 1, "R7");
    drive(1, 1, "R7");
    drive(0, 0, "R7");
    drive(0, 1, "R7");
    drive(0, 1, "R7");
    // Random traffic with all rules checked each cycle
    for (int i = 0; i < 400; i++) begin
      logic h;
      logic l;
      h = ($urandom % 3) == 0;
      l = $urandom % 2;
      drive(h, l, "R2");
    end
    drive(0, 0, "R5");
    drive(0, 0, "R5");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule